// File: doc/BRIEF.md
# Hot key detector with a two-row count-min sketch

The block watches a stream of 64-bit keys and flags those that recur often. Every accepted key is hashed twice, with a different CRC-16 polynomial for each hash. Each hash picks one counter in its own counter row, and both picked counters are incremented. If both incremented values exceed a runtime threshold, the block raises a report that carries the key. It also sets both of that key's counters back to zero, so the key has to earn its next report from scratch. Taking the smaller of two independently hashed counts removes most of the over-counting that a single hashed row would suffer from colliding keys.

The counter update is a two-cycle read-modify-write pipeline. Forwarding lets consecutive keys that land on the same counter see each other's updates. The report output is a valid/ready pair. While a report waits for its consumer, the input side stalls, so no report is ever lost. The number of counter slots per row is a parameter. Its default is kept small, and a deployment sets the index width to 16 to get 65536 slots of 16 bits per row.

Top module: `hot_key_detector`

## Requirements
- R1: After reset `rpt_valid` is 0, `in_ready` is 1 and every counter in both rows reads zero.
- R2: Row A's slot is the low `IDX_W` bits of a CRC-16 with polynomial 0x1021. Row B's slot uses the same CRC with polynomial 0x8005. Both CRCs start from 0xFFFF and take the key most significant bit first, bit 63 down to bit 0, with no reflection and no final XOR.
- R3: Every key accepted (`in_valid` and `in_ready` high at a rising edge) increments the row A counter and the row B counter that it addresses, once each.
- R4: When both incremented values of an accepted key are strictly greater than `thresh`, one report carrying that key is issued. Reports leave in the order their keys were accepted, two clock edges after acceptance when the output is not stalled.
- R5: A reported key sets both of its addressed counters to zero, so later keys see those slots as freshly cleared.
- R6: A counter at 0xFFFF stays at 0xFFFF when incremented.
- R7: Keys accepted on consecutive cycles that address the same slot are all counted. None of their increments is lost.
- R8: A new `thresh` value applies to every key accepted at least one clock after the value is written.
- R9: While `rpt_valid` is high and `rpt_ready` is low, `in_ready` is low, and `rpt_valid` and `rpt_key` hold steady until the report is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Key present on `in_key` |
| in_key | input | 64 | Key to count |
| in_ready | output | 1 | Block can take a key this cycle |
| thresh | input | CNT_W | Hot threshold, compared with the smaller count |
| rpt_valid | output | 1 | A hot-key report is offered |
| rpt_ready | input | 1 | Consumer takes the report |
| rpt_key | output | 64 | Key of the offered report |

## Verification
A single key is repeated back to back, which exercises forwarding and gives an exact report cycle. Repeating that key after a report shows whether the counters were really cleared. A burst from a small pool of keys with a low threshold forces many slot collisions. That burst only matches a behavioural sketch model if both hashes and both rows are right, and random backpressure during it exercises the stall path. A run of more than 65535 copies of one key, followed by a threshold just below the maximum, tells saturation apart from wrap-around.

// File: rtl/hotdet_pkg.sv
package hotdet_pkg;

  localparam int unsigned KEY_BITS = 64;
  localparam int unsigned CRC_BITS = 16;

  typedef logic [KEY_BITS-1:0] key_t;
  typedef logic [CRC_BITS-1:0] crc_t;

  // Bit-serial CRC-16, seed all ones, key taken MSB first (R2)
  function automatic crc_t crc16_key(input crc_t poly, input key_t key);
    crc_t r;
    logic fb;
    r = '1;
    for (int i = KEY_BITS - 1; i >= 0; i--) begin
      fb = r[CRC_BITS-1] ^ key[i];
      r  = {r[CRC_BITS-2:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

endpackage

// File: rtl/hotdet_hash.sv
module hotdet_hash
  import hotdet_pkg::*;
#(
  parameter crc_t POLY  = 16'h1021,
  parameter int   IDX_W = 8
) (
  input  key_t             key,
  output logic [IDX_W-1:0] idx
);

  function automatic logic [IDX_W-1:0] slot_of(input key_t k);
    crc_t full;
    full = crc16_key(POLY, k);
    return full[IDX_W-1:0];
  endfunction

  assign idx = slot_of(key);

endmodule

// File: rtl/hotdet_row.sv
module hotdet_row #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             look_vld,
  input  logic [IDX_W-1:0] look_idx,
  output logic [CNT_W-1:0] look_next,
  input  logic             commit_clr
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Saturating increment (R6)
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? CNT_MAX : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] mem [DEPTH];
  logic             s2_vld;
  logic [IDX_W-1:0] s2_idx;
  logic [CNT_W-1:0] s2_val;

  logic             wr_en;
  logic [CNT_W-1:0] wr_val;
  logic             fwd_hit;
  logic [CNT_W-1:0] look_cur;

  assign wr_en     = adv && s2_vld;
  assign wr_val    = commit_clr ? '0 : s2_val;
  // Forward the pending write to a lookup of the same slot (R7)
  assign fwd_hit   = s2_vld && (s2_idx == look_idx);
  assign look_cur  = fwd_hit ? wr_val : mem[look_idx];
  assign look_next = sat_inc(look_cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      s2_vld <= 1'b0;
      s2_idx <= '0;
      s2_val <= '0;
    end else begin
      if (wr_en) mem[s2_idx] <= wr_val;
      if (adv) begin
        s2_vld <= look_vld;
        s2_idx <= look_idx;
        s2_val <= look_next;
      end
    end
  end

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (look_vld && look_cur == CNT_MAX) |-> (look_next == CNT_MAX));

  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !commit_clr) |-> (wr_val != '0));

  assert_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && commit_clr) |=> (mem[$past(s2_idx)] == '0));

endmodule

// File: rtl/hot_key_detector.sv
module hot_key_detector
  import hotdet_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [KEY_BITS-1:0] in_key,
  output logic                in_ready,
  input  logic [CNT_W-1:0]    thresh,
  output logic                rpt_valid,
  input  logic                rpt_ready,
  output logic [KEY_BITS-1:0] rpt_key
);

  localparam int ROWS = 2;
  localparam crc_t POLY_TAB [ROWS] = '{16'h1021, 16'h8005};

  function automatic logic above(input logic [CNT_W-1:0] a,
                                 input logic [CNT_W-1:0] b,
                                 input logic [CNT_W-1:0] t);
    logic [CNT_W-1:0] m;
    m = (a < b) ? a : b;
    return m > t;
  endfunction

  logic             adv;
  logic [IDX_W-1:0] hash_idx [ROWS];
  logic [IDX_W-1:0] s1_idx   [ROWS];
  logic [CNT_W-1:0] row_next [ROWS];
  logic             s1_vld;
  key_t             s1_key;
  logic             s2_vld;
  logic             s2_hot;
  key_t             s2_key;
  logic             hot_now;

  // The whole pipe moves only when the report slot is free or being taken (R9)
  assign adv      = !(rpt_valid && !rpt_ready);
  assign in_ready = adv;
  assign hot_now  = above(row_next[0], row_next[1], thresh);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    hotdet_hash #(.POLY(POLY_TAB[r]), .IDX_W(IDX_W)) u_hash (
      .key (in_key),
      .idx (hash_idx[r])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)   s1_idx[r] <= '0;
      else if (adv) s1_idx[r] <= hash_idx[r];
    end

    hotdet_row #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_row (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (adv),
      .look_vld   (s1_vld),
      .look_idx   (s1_idx[r]),
      .look_next  (row_next[r]),
      .commit_clr (s2_hot)
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_key    <= '0;
      s2_vld    <= 1'b0;
      s2_hot    <= 1'b0;
      s2_key    <= '0;
      rpt_valid <= 1'b0;
      rpt_key   <= '0;
    end else if (adv) begin
      s1_vld    <= in_valid;
      s1_key    <= in_key;
      s2_vld    <= s1_vld;
      s2_hot    <= s1_vld && hot_now;
      s2_key    <= s1_key;
      rpt_valid <= s2_vld && s2_hot;
      if (s2_vld && s2_hot) rpt_key <= s2_key;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_key)));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |-> !in_ready);

  assert_report_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_vld && s2_hot) |=> (rpt_valid && rpt_key == $past(s2_key)));

  assert_no_idle_report_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !(s2_vld && s2_hot)) |=> !rpt_valid);

endmodule

// File: tb/hot_key_detector_tb.sv
`timescale 1ns/1ps
module hot_key_detector_tb;

  localparam int IDX_W = 8;
  localparam int CNT_W = 16;
  localparam int DEPTH = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [63:0]       in_key;
  logic              in_ready;
  logic [CNT_W-1:0]  thresh;
  logic              rpt_valid;
  logic              rpt_ready;
  logic [63:0]       rpt_key;

  always #2.5 clk = ~clk;

  hot_key_detector #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
    .in_ready(in_ready), .thresh(thresh), .rpt_valid(rpt_valid),
    .rpt_ready(rpt_ready), .rpt_key(rpt_key)
  );

  int          cnt_a [DEPTH];
  int          cnt_b [DEPTH];
  logic [63:0] expq [$];
  int          n_cmp = 0, n_bad = 0, n_rep = 0;
  bit          mon_on = 0, prev_stall = 0, bp_mode = 0, done = 0;
  logic [63:0] prev_key;
  int unsigned lfsr = 32'h1234_5678;

  // Byte-wise restatement of the CRC (R2)
  function automatic int ref_slot(int poly, logic [63:0] k);
    int c = 32'hFFFF;
    for (int b = 7; b >= 0; b--) begin
      c = c ^ (int'(k[b*8 +: 8]) << 8);
      for (int j = 0; j < 8; j++)
        c = (c & 32'h8000) ? (((c << 1) ^ poly) & 32'hFFFF) : ((c << 1) & 32'hFFFF);
    end
    return c % DEPTH;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Reference model, compared every cycle
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (prev_stall)
        check(rpt_valid && rpt_key == prev_key, "R9 hold", rpt_key, prev_key);
      check(in_ready == !(rpt_valid && !rpt_ready), "R9 stall", in_ready, !(rpt_valid && !rpt_ready));
      if (rpt_valid) begin
        if (expq.size() == 0) check(0, "R4 spurious report", rpt_key, 0);
        else check(rpt_key == expq[0], "R4 report key", rpt_key, expq[0]);
        if (rpt_ready) begin
          n_rep++;
          if (expq.size() > 0) void'(expq.pop_front());
        end
      end
      prev_stall = rpt_valid && !rpt_ready;
      prev_key   = rpt_key;
      if (in_valid && in_ready) begin
        int ia, ib;
        ia = ref_slot(32'h1021, in_key);
        ib = ref_slot(32'h8005, in_key);
        if (cnt_a[ia] < 65535) cnt_a[ia]++;
        if (cnt_b[ib] < 65535) cnt_b[ib]++;
        if (cnt_a[ia] > int'(thresh) && cnt_b[ib] > int'(thresh)) begin
          expq.push_back(in_key);
          cnt_a[ia] = 0;
          cnt_b[ib] = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    rpt_ready <= bp_mode ? lfsr[3] : 1'b1;
  end

  task automatic send(logic [63:0] k);
    @(negedge clk);
    in_valid <= 1'b1;
    in_key   <= k;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid <= 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [63:0] k1, k2, k3;
    int base;
    for (int i = 0; i < DEPTH; i++) begin cnt_a[i] = 0; cnt_b[i] = 0; end
    k1 = 64'h0123_4567_89AB_CDEF;
    k2 = 64'hFEDC_BA98_7654_3210;
    k3 = 64'hDEAD_BEEF_0BAD_F00D;
    rst_n = 1'b0; in_valid = 1'b0; in_key = '0; thresh = 16'd3;
    repeat (4) @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    #2;
    check(rpt_valid == 1'b0, "R1 rpt_valid after reset", rpt_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    mon_on = 1;

    // R3 R7: four back-to-back copies against threshold 3
    repeat (4) send(k1);
    idle(6);
    check(n_rep == 1, "R3 R7 one report after four hits", n_rep, 1);

    // R5: counters restart after the report
    repeat (3) send(k1);
    idle(6);
    check(n_rep == 1, "R5 no report at three hits after clear", n_rep, 1);
    send(k1);
    idle(6);
    check(n_rep == 2, "R5 report on fourth hit after clear", n_rep, 2);

    // R8: lower threshold applies to later keys
    thresh <= 16'd1;
    idle(3);
    repeat (2) send(k2);
    idle(6);
    check(n_rep == 3, "R8 report at new threshold", n_rep, 3);

    // R2 R9: colliding pool under random backpressure
    thresh <= 16'd2;
    bp_mode = 1;
    idle(3);
    for (int i = 0; i < 3000; i++) begin
      send(64'h9E37_79B9_7F4A_7C15 * ((lfsr % 40) + 1));
      if (lfsr[7:5] == 3'd0) idle(2);
    end
    idle(40);
    bp_mode = 0;
    idle(4);
    check(expq.size() == 0, "R2 R9 all predicted reports delivered", expq.size(), 0);

    // R6: saturation
    thresh <= 16'hFFFF;
    idle(3);
    base = n_rep;
    repeat (66000) send(k3);
    idle(8);
    check(n_rep == base, "R6 no report at maximum threshold", n_rep, base);
    thresh <= 16'hFFFE;
    idle(3);
    send(k3);
    idle(8);
    check(n_rep == base + 1, "R6 saturated count exceeds 0xFFFE", n_rep, base + 1);
    check(expq.size() == 0, "R4 queue drained", expq.size(), 0);

    done = 1;
    summary();
  end

endmodule